// File: doc/BRIEF.md
# Three-Mode Game Action Controller

This block turns button presses from a handheld game into character actions. The character is always in one of three modes: Idle, Fight or React. Each button press either switches the mode or leaves the mode as it is and produces an action. The two action buttons give different actions in different modes. Fight mode and React mode each have their own toggle button. There is no direct path between Fight and React: the character has to pass through Idle.

A press arrives as a 2-bit code with a valid strobe. It is sampled on a rising clock edge. The new mode, the action code and an action-valid flag all come from registers, so they change on that same edge. The action output keeps its last value until the next action is emitted. The current mode is also brought out so that it can be observed.

Top module: `game_action_fsm`

## Requirements
- R1: While `rst_n` is low at a rising edge (synchronous, active-low), the mode becomes Idle (0), the action becomes Run (4) and action-valid goes low. Reset takes priority over a valid press in the same cycle.
- R2: At an edge where `btn_vld_i` is low, the mode and the action hold their values and action-valid goes low.
- R3: In Idle, a valid press of A (code 2) or B (code 3) keeps the mode Idle and emits Run (4) with action-valid high.
- R4: In Idle, a valid Fight press (code 0) moves to Fight (mode 1), and a valid React press (code 1) moves to React (mode 2). Both emit Run (4) with action-valid high.
- R5: In Fight, A emits Kick (0) and B emits Punch (1). The mode stays Fight.
- R6: In React, A emits Jump (2) and B emits Duck (3). The mode stays React.
- R7: In Fight, a Fight press returns to Idle. In React, a React press returns to Idle. In both cases Run (4) is emitted with action-valid high.
- R8: A React press in Fight, or a Fight press in React, is ignored: the mode and the action hold and action-valid goes low.
- R9: Whenever the mode is Idle, the action output is Run (4).
- R10: The outputs are registered. A press changes `mode_o`, `act_o` and `act_vld_o` at the edge that samples it, and not before. The mode code 3 is not legal and returns to Idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_code_i | input | 2 | Button code: Fight 0, React 1, A 2, B 3 |
| btn_vld_i | input | 1 | High when `btn_code_i` carries a press |
| act_o | output | 3 | Action: Kick 0, Punch 1, Jump 2, Duck 3, Run 4 |
| act_vld_o | output | 1 | High for one cycle after each emitted action |
| mode_o | output | 2 | Current mode: Idle 0, Fight 1, React 2 |

## Verification
A mode change and an action emission can fall in the same cycle. This happens when a toggle press leaves Fight or React: the mode returns to Idle on the same edge where Run is emitted. The bench sweeps every mode with every button code, both with and without the strobe. After each edge it compares mode, action and flag together against an arithmetic model, so a design that sequences the change and the emission across two cycles is caught. Reset is also applied in the same cycle as a valid press, and the bench checks that reset wins.

// File: rtl/game_action_pkg.sv
// Package: shared widths and codes for the game action controller.
// Assumes the numeric codes below are fixed by the system that uses the block.
package game_action_pkg;

    localparam int BTN_W  = 2;
    localparam int ACT_W  = 3;
    localparam int MODE_W = 2;

    // button codes seen on the input
    localparam logic [BTN_W-1:0] BTN_FIGHT = 2'd0;
    localparam logic [BTN_W-1:0] BTN_REACT = 2'd1;
    localparam logic [BTN_W-1:0] BTN_A     = 2'd2;
    localparam logic [BTN_W-1:0] BTN_B     = 2'd3;

    // action codes driven on the output
    localparam logic [ACT_W-1:0] ACT_KICK  = 3'd0;
    localparam logic [ACT_W-1:0] ACT_PUNCH = 3'd1;
    localparam logic [ACT_W-1:0] ACT_JUMP  = 3'd2;
    localparam logic [ACT_W-1:0] ACT_DUCK  = 3'd3;
    localparam logic [ACT_W-1:0] ACT_RUN   = 3'd4;

    // mode codes held in the mode register
    localparam logic [MODE_W-1:0] MODE_IDLE  = 2'd0;
    localparam logic [MODE_W-1:0] MODE_FIGHT = 2'd1;
    localparam logic [MODE_W-1:0] MODE_REACT = 2'd2;

endpackage

// File: rtl/game_action_decode.sv
// Module: game_action_decode
// Purely combinational next-mode and action decision.
// Assumes: mode_i comes from the mode register; any code that is not a legal
// mode sends the machine to Idle and reloads Run without flagging an action.
module game_action_decode
    import game_action_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    input  logic [BTN_W-1:0]  btn_code_i,
    input  logic              btn_vld_i,
    output logic [MODE_W-1:0] mode_nxt_o,
    output logic              act_load_o,
    output logic [ACT_W-1:0]  act_code_o,
    output logic              act_flag_o
);

    // Decide the next mode and the action for this press.
    always_comb begin
        mode_nxt_o = mode_i;
        act_load_o = 1'b0;
        act_code_o = ACT_RUN;
        act_flag_o = 1'b0;
        case (mode_i)
            MODE_IDLE: begin
                if (btn_vld_i) begin
                    act_load_o = 1'b1;
                    act_flag_o = 1'b1;
                    act_code_o = ACT_RUN;
                    if (btn_code_i == BTN_FIGHT) begin
                        mode_nxt_o = MODE_FIGHT;
                    end else if (btn_code_i == BTN_REACT) begin
                        mode_nxt_o = MODE_REACT;
                    end
                end
            end
            MODE_FIGHT: begin
                if (btn_vld_i) begin
                    case (btn_code_i)
                        BTN_FIGHT: begin
                            mode_nxt_o = MODE_IDLE;
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_RUN;
                        end
                        BTN_A: begin
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_KICK;
                        end
                        BTN_B: begin
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_PUNCH;
                        end
                        default: begin
                            // cross-mode button: no effect
                            mode_nxt_o = mode_i;
                        end
                    endcase
                end
            end
            MODE_REACT: begin
                if (btn_vld_i) begin
                    case (btn_code_i)
                        BTN_REACT: begin
                            mode_nxt_o = MODE_IDLE;
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_RUN;
                        end
                        BTN_A: begin
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_JUMP;
                        end
                        BTN_B: begin
                            act_load_o = 1'b1;
                            act_flag_o = 1'b1;
                            act_code_o = ACT_DUCK;
                        end
                        default: begin
                            // cross-mode button: no effect
                            mode_nxt_o = mode_i;
                        end
                    endcase
                end
            end
            default: begin
                mode_nxt_o = MODE_IDLE;
                act_load_o = 1'b1;
                act_code_o = ACT_RUN;
            end
        endcase
    end

endmodule

// File: rtl/game_mode_reg.sv
// Module: game_mode_reg
// Holds the current mode; synchronous active-low reset to Idle.
// Assumes mode_nxt_i is produced by the decoder in the same cycle.
module game_mode_reg
    import game_action_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_nxt_i,
    output logic [MODE_W-1:0] mode_o
);

    // Register the next mode every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_o <= MODE_IDLE;
        end else begin
            mode_o <= mode_nxt_i;
        end
    end

    // R10: only legal codes ever appear after reset
    p_mode_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mode_o != 2'd3));

endmodule

// File: rtl/game_act_reg.sv
// Module: game_act_reg
// Holds the action code and the one-cycle valid flag.
// Assumes load/flag come from the decoder; the code holds when not loaded.
module game_act_reg
    import game_action_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_load_i,
    input  logic [ACT_W-1:0] act_code_i,
    input  logic             act_flag_i,
    output logic [ACT_W-1:0] act_o,
    output logic             act_vld_o
);

    // Load the action on request and pulse the valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o     <= ACT_RUN;
            act_vld_o <= 1'b0;
        end else begin
            act_vld_o <= act_flag_i;
            if (act_load_i) begin
                act_o <= act_code_i;
            end
        end
    end

    // R2/R8: the action holds whenever nothing is loaded
    p_act_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !act_load_i |=> $stable(act_o));

endmodule

// File: rtl/game_action_fsm.sv
// Module: game_action_fsm (top)
// Three-mode game character controller: decoder plus mode and action registers.
// Assumes btn_code_i is meaningful only while btn_vld_i is high; all outputs
// are registered and reset synchronously with rst_n low.
module game_action_fsm
    import game_action_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BTN_W-1:0]  btn_code_i,
    input  logic              btn_vld_i,
    output logic [ACT_W-1:0]  act_o,
    output logic              act_vld_o,
    output logic [MODE_W-1:0] mode_o
);

    logic [MODE_W-1:0] mode_nxt;
    logic              act_load;
    logic [ACT_W-1:0]  act_code;
    logic              act_flag;

    game_action_decode u_dec (
        .mode_i     (mode_o),
        .btn_code_i (btn_code_i),
        .btn_vld_i  (btn_vld_i),
        .mode_nxt_o (mode_nxt),
        .act_load_o (act_load),
        .act_code_o (act_code),
        .act_flag_o (act_flag)
    );

    game_mode_reg u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_nxt_i (mode_nxt),
        .mode_o     (mode_o)
    );

    game_act_reg u_act (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_load_i (act_load),
        .act_code_i (act_code),
        .act_flag_i (act_flag),
        .act_o      (act_o),
        .act_vld_o  (act_vld_o)
    );

    // R9: Idle always shows Run
    p_idle_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && (mode_o == MODE_IDLE) |-> (act_o == ACT_RUN));

    // R2: no strobe means no action and no mode change
    p_no_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_vld_i |=> (!act_vld_o && $stable(mode_o)));

    // R8: cross-mode buttons are ignored
    p_no_cross_r8: assert property (@(posedge clk) disable iff (!rst_n)
        btn_vld_i && (((mode_o == MODE_FIGHT) && (btn_code_i == BTN_REACT)) ||
                      ((mode_o == MODE_REACT) && (btn_code_i == BTN_FIGHT)))
        |=> (!act_vld_o && $stable(mode_o)));

    // R7: leaving Fight lands in Idle with Run in the same cycle
    p_fight_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        btn_vld_i && (mode_o == MODE_FIGHT) && (btn_code_i == BTN_FIGHT)
        |=> ((mode_o == MODE_IDLE) && act_vld_o && (act_o == ACT_RUN)));

    // R5: Fight maps A to Kick
    p_fight_kick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        btn_vld_i && (mode_o == MODE_FIGHT) && (btn_code_i == BTN_A)
        |=> (act_vld_o && (act_o == ACT_KICK) && (mode_o == MODE_FIGHT)));

    // R6: React maps B to Duck
    p_react_duck_r6: assert property (@(posedge clk) disable iff (!rst_n)
        btn_vld_i && (mode_o == MODE_REACT) && (btn_code_i == BTN_B)
        |=> (act_vld_o && (act_o == ACT_DUCK) && (mode_o == MODE_REACT)));

endmodule

// File: tb/game_action_fsm_test.sv
module game_action_fsm_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] btn_code = 2'd0;
    logic       btn_vld = 1'b0;
    logic [2:0] act;
    logic       act_vld;
    logic [1:0] mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference state
    int em = 0;
    int ea = 4;
    int ev = 0;

    always #5 clk = ~clk;

    game_action_fsm uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .btn_code_i (btn_code),
        .btn_vld_i  (btn_vld),
        .act_o      (act),
        .act_vld_o  (act_vld),
        .mode_o     (mode)
    );

    // Reference model derived from the requirement list.
    task automatic model(input int b, input int v);
        ev = 0;
        if (v == 0) return;
        if (em == 0) begin
            ea = 4; ev = 1;
            if (b == 0) em = 1;
            else if (b == 1) em = 2;
        end else if (em == 1) begin
            if (b == 0) begin em = 0; ea = 4; ev = 1; end
            else if (b >= 2) begin ea = b - 2; ev = 1; end
        end else begin
            if (b == 1) begin em = 0; ea = 4; ev = 1; end
            else if (b >= 2) begin ea = b; ev = 1; end
        end
    endtask

    task automatic check(input string tag);
        checks++;
        if (mode !== em[1:0] || act !== ea[2:0] || act_vld !== ev[0]) begin
            errors++;
            $display("FAIL %s: mode/act/vld actual %0d/%0d/%0d expected %0d/%0d/%0d",
                     tag, mode, act, act_vld, em, ea, ev);
        end
    endtask

    task automatic press(input int b, input int v);
        @(negedge clk);
        btn_code = b[1:0];
        btn_vld  = v[0];
        @(posedge clk);
        #2;
        model(b, v);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        btn_vld = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        em = 0; ea = 4; ev = 0;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic string tag_for(int m, int b, int v);
        if (v == 0) return "R2 no strobe";
        if (m == 0) return (b < 2) ? "R4 enter mode" : "R3 idle run";
        if (m == 1) return (b == 0) ? "R7 exit fight" : (b == 1) ? "R8 cross ignored" : "R5 fight action";
        return (b == 1) ? "R7 exit react" : (b == 0) ? "R8 cross ignored" : "R6 react action";
    endfunction

    initial begin : watchdog
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // exhaustive sweep: every mode x every code x strobe on/off
        for (int m = 0; m < 3; m++) begin
            for (int b = 0; b < 4; b++) begin
                for (int v = 0; v < 2; v++) begin
                    do_reset();
                    if (m != 0) begin
                        press(m - 1, 1);
                        check("R4 setup");
                    end
                    // R8/R2: load a non-Run action first so holds are visible
                    if (m != 0) begin
                        press(3, 1);
                        check(m == 1 ? "R5 setup" : "R6 setup");
                    end
                    press(b, v);
                    check(tag_for(m, b, v));
                    if (mode == 2'd0) begin
                        checks++;
                        if (act !== 3'd4) begin
                            errors++;
                            $display("FAIL R9: act actual %0d expected 4", act);
                        end
                    end
                end
            end
        end

        // R10: outputs do not move before the sampling edge
        do_reset();
        @(negedge clk);
        btn_code = 2'd0;
        btn_vld  = 1'b1;
        #2;
        check("R10 before edge");
        @(posedge clk);
        #2;
        model(0, 1);
        check("R10 at edge");

        // R1: reset wins over a press in the same cycle
        press(2, 1);
        check("R5 kick");
        @(negedge clk);
        rst_n = 1'b0;
        btn_code = 2'd0;
        btn_vld = 1'b1;
        @(posedge clk);
        #2;
        em = 0; ea = 4; ev = 0;
        check("R1 reset over press");
        @(negedge clk);
        rst_n = 1'b1;
        btn_vld = 1'b0;

        // replay a pseudo-random button stream against the model
        begin
            logic [7:0] lfsr = 8'hA5;
            for (int i = 0; i < 400; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                press(int'(lfsr[1:0]), (lfsr[6:4] != 3'd0) ? 1 : 0);
                check("R10 replay");
                if (mode == 2'd0) begin
                    checks++;
                    if (act !== 3'd4) begin
                        errors++;
                        $display("FAIL R9 replay: act actual %0d expected 4", act);
                    end
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule